// File: doc/BRIEF.md
# ADC Result Register Pair with Read Lock

This block holds the most recent 10-bit conversion result of an analog-to-digital converter. A processor bus sees it as two 8-bit read-only registers, a low byte and a high byte. A conversion-complete strobe delivers each new result. An adjust control bit chooses right or left alignment of the 10 bits across the two bytes. The stored value is reformatted on every read, so changing the adjust bit never alters the stored value.

A two-byte read is kept consistent by a lock. Reading the low byte freezes the visible value until the high byte is read. A result that arrives in the meantime waits in a one-entry pending slot, and the releasing high-byte read commits it on the same edge. A reader that needs only 8 bits can use left alignment and read the high byte alone, with no side effect. Differential results in two's complement are stored unchanged, with no sign extension.

Top module: `adc_result_regs`

## Requirements
- R1: After reset both bytes read as 0x00 and no lock is held.
- R2: With adj_left = 0, the high byte is {6'b0, result[9:8]} and the low byte is result[7:0].
- R3: With adj_left = 1, the high byte is result[9:2] and the low byte is {result[1:0], 6'b0}.
- R4: With no lock held, a result sampled with res_valid on an edge is readable from the cycle after that edge.
- R5: A low-byte read (rd_lo sampled high, rd_hi low) sets the lock. While the lock is held, later results do not change either byte until a high-byte read is sampled.
- R6: A result arriving while locked goes into a pending slot, and a newer one overwrites it. The high-byte read that releases the lock commits the pending slot on that edge. A result that arrives on the releasing edge itself takes precedence.
- R7: A high-byte read with no lock held returns the current high byte and leaves the lock clear, so a later result becomes visible at once.
- R8: The adjust bit only selects formatting at read time. Toggling it re-presents the same stored value.
- R9: A result whose res_valid coincides with a lock-setting low-byte read goes to the pending slot, so the pair read returns the older value.
- R10: rd_data is 0x00 when no strobe is high. With both strobes high it returns the low byte, and the lock is clear afterwards.
- R11: A two's-complement result such as 10'h200 is stored and presented bit for bit, with no sign extension into the zero-filled bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Conversion-complete strobe |
| res_data | input | 10 | Conversion result |
| adj_left | input | 1 | 1 = left-aligned presentation |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| rd_data | output | 8 | Combinational read data |

## Verification
The formatting path is driven with all-ones, alternating 01 and 10 bit patterns, a lone sign bit and a lone LSB, each under both alignments. These patterns show a swapped or shifted bit, a wrong zero fill, and any sign extension. The lock path is driven with results that arrive before the low read, between the two reads, twice between them, on the low-read edge and on the releasing edge. This separates a missing lock, a lost or stale pending slot, and the wrong precedence on the release edge. High-only reads and dual-strobe reads show whether a lock leaks from an access that must leave it clear.

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  input  logic              adj_left,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int HI_BITS = RES_W - BYTE_W;
  localparam int PAD_W   = 2*BYTE_W - RES_W;

  logic [RES_W-1:0] cur_q, pend_q;
  logic             lock_q, pend_vld_q;

  logic [2*BYTE_W-1:0] word_r, word_l, word;
  assign word_r = {{PAD_W{1'b0}}, cur_q};
  assign word_l = {cur_q, {PAD_W{1'b0}}};
  assign word   = adj_left ? word_l : word_r;

  assign rd_data = rd_lo ? word[BYTE_W-1:0] :
                   rd_hi ? word[2*BYTE_W-1:BYTE_W] : '0;

  logic release_ev, lock_ev;
  assign release_ev = lock_q && rd_hi;
  assign lock_ev    = !lock_q && rd_lo && !rd_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q      <= '0;
      pend_q     <= '0;
      lock_q     <= 1'b0;
      pend_vld_q <= 1'b0;
    end else if (release_ev) begin
      lock_q     <= 1'b0;
      pend_vld_q <= 1'b0;
      if (res_valid)       cur_q <= res_data;
      else if (pend_vld_q) cur_q <= pend_q;
    end else if (lock_q || lock_ev) begin
      lock_q <= 1'b1;
      if (res_valid) begin
        pend_q     <= res_data;
        pend_vld_q <= 1'b1;
      end
    end else if (res_valid) begin
      cur_q <= res_data;
    end
  end

  logic unused_ok;
  assign unused_ok = ^HI_BITS;
endmodule

module adc_result_regs_chk #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic [RES_W-1:0]  res_data,
  input logic              adj_left,
  input logic              rd_lo,
  input logic              rd_hi,
  input logic [BYTE_W-1:0] rd_data,
  input logic [RES_W-1:0]  cur_q,
  input logic [RES_W-1:0]  pend_q,
  input logic              lock_q,
  input logic              pend_vld_q
);
  p_right_zero_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adj_left && rd_hi && !rd_lo) |-> rd_data[BYTE_W-1:RES_W-BYTE_W] == '0);
  p_left_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_left && rd_lo) |-> rd_data[2*BYTE_W-RES_W-1:0] == '0);
  p_unlocked_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !lock_q && !rd_lo) |=> cur_q == $past(res_data));
  p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !rd_hi) |=> ($stable(cur_q) && lock_q));
  p_commit_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && rd_hi && pend_vld_q && !res_valid) |=> (cur_q == $past(pend_q) && !lock_q));
  p_hi_only_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && rd_hi) |=> !lock_q);
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_lo && !rd_hi) |-> rd_data == '0);
endmodule

bind adc_result_regs adc_result_regs_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
  .adj_left(adj_left), .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data),
  .cur_q(cur_q), .pend_q(pend_q), .lock_q(lock_q), .pend_vld_q(pend_vld_q)
);

// File: tb/adc_result_regs_bench.sv
module adc_result_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic [9:0] res_data = '0;
  logic       adj_left = 1'b0;
  logic       rd_lo = 1'b0;
  logic       rd_hi = 1'b0;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  adc_result_regs u_adc_result_regs (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .adj_left(adj_left), .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data)
  );

  // {result, adj_left, expected low, expected high}
  localparam logic [26:0] VEC [10] = '{
    {10'h3FF, 1'b0, 8'hFF, 8'h03}, {10'h3FF, 1'b1, 8'hC0, 8'hFF},
    {10'h155, 1'b0, 8'h55, 8'h01}, {10'h155, 1'b1, 8'h40, 8'h55},
    {10'h2AA, 1'b0, 8'hAA, 8'h02}, {10'h2AA, 1'b1, 8'h80, 8'hAA},
    {10'h200, 1'b0, 8'h00, 8'h02}, {10'h200, 1'b1, 8'h00, 8'h80},
    {10'h001, 1'b0, 8'h01, 8'h00}, {10'h001, 1'b1, 8'h40, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic conv(input logic [9:0] d);
    @(negedge clk); res_data = d; res_valid = 1'b1;
    @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic rd(input bit lo, output logic [7:0] v);
    @(negedge clk); rd_lo = lo; rd_hi = !lo; #1 v = rd_data;
    @(negedge clk); rd_lo = 1'b0; rd_hi = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(1'b0, v); chk("R1 hi after reset", v, 8'h00);
    rd(1'b1, v); chk("R1 lo after reset", v, 8'h00);
    rd(1'b0, v);

    // R2 R3 R11: formatting table
    for (int i = 0; i < 10; i++) begin
      adj_left = VEC[i][16];
      conv(VEC[i][26:17]);
      rd(1'b1, v); chk(VEC[i][16] ? "R3 lo" : "R2 lo", v, VEC[i][15:8]);
      rd(1'b0, v); chk(VEC[i][16] ? "R3 hi" : "R2 hi", v, VEC[i][7:0]);
    end

    // R4: unlocked update visible the cycle after the edge
    adj_left = 1'b0;
    @(negedge clk); res_data = 10'h1A5; res_valid = 1'b1;
    @(negedge clk); res_valid = 1'b0; rd_hi = 1'b1; #1 chk("R4 next cycle", rd_data, 8'h01);
    @(negedge clk); rd_hi = 1'b0;

    // R5: lock holds
    rd(1'b1, v); chk("R5 lo", v, 8'hA5);
    conv(10'h0F0);
    rd(1'b1, v); chk("R5 lo held", v, 8'hA5);
    rd(1'b0, v); chk("R5 hi held", v, 8'h01);
    rd(1'b1, v); chk("R6 committed lo", v, 8'hF0);
    rd(1'b0, v); chk("R6 committed hi", v, 8'h00);

    // R6: newest pending wins
    rd(1'b1, v);
    conv(10'h111); conv(10'h2CC);
    rd(1'b0, v); chk("R6 hi of old", v, 8'h00);
    rd(1'b1, v); chk("R6 overwrite lo", v, 8'hCC);
    rd(1'b0, v); chk("R6 overwrite hi", v, 8'h02);

    // R6: result on the release edge beats pending
    rd(1'b1, v);
    conv(10'h033);
    @(negedge clk); rd_hi = 1'b1; res_data = 10'h377; res_valid = 1'b1;
    @(negedge clk); rd_hi = 1'b0; res_valid = 1'b0;
    rd(1'b1, v); chk("R6 release-edge lo", v, 8'h77);
    rd(1'b0, v); chk("R6 release-edge hi", v, 8'h03);

    // R7: high-only read has no side effect
    rd(1'b0, v); chk("R7 hi only", v, 8'h03);
    conv(10'h244);
    rd(1'b0, v); chk("R7 no lock", v, 8'h02);

    // R8: adjust bit reformats the same stored value
    adj_left = 1'b1;
    rd(1'b0, v); chk("R8 left hi", v, 8'h91);
    adj_left = 1'b0;
    rd(1'b0, v); chk("R8 right hi", v, 8'h02);

    // R9: result coinciding with lock-setting low read
    @(negedge clk); rd_lo = 1'b1; res_data = 10'h155; res_valid = 1'b1; #1 v = rd_data;
    chk("R9 lo old", v, 8'h44);
    @(negedge clk); rd_lo = 1'b0; res_valid = 1'b0;
    rd(1'b0, v); chk("R9 hi old", v, 8'h02);
    rd(1'b1, v); chk("R9 lo new", v, 8'h55);
    rd(1'b0, v); chk("R9 hi new", v, 8'h01);

    // R10: idle data and dual strobes
    @(negedge clk); #1 chk("R10 idle zero", rd_data, 8'h00);
    @(negedge clk); rd_lo = 1'b1; rd_hi = 1'b1; #1 chk("R10 dual returns lo", rd_data, 8'h55);
    @(negedge clk); rd_lo = 1'b0; rd_hi = 1'b0;
    conv(10'h0AB);
    rd(1'b0, v); chk("R10 no lock after dual", v, 8'h00);
    rd(1'b1, v); chk("R10 new lo", v, 8'hAB);
    rd(1'b0, v);

    // R1: reset mid-lock clears value and lock
    rd(1'b1, v);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    conv(10'h3C3);
    rd(1'b0, v); chk("R1 lock cleared by reset", v, 8'h03);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule